// File: doc/BRIEF.md
# Zero-Compressed Double-Column Readout Sequencer

This block sits at the foot of one double column of a hybrid pixel matrix and controls it. When a start token arrives from the previous double column, it serializes the column's contents into a single bit stream. It uses hit flags at three levels so that empty parts cost as few bits as possible.

The stream starts with one column flag. If that flag is set, one flag follows for each super-pixel, in ascending order. After a set super-pixel flag come one flag per pixel and then, for each hit pixel only, its data word with the most significant bit first. When the last bit has been sent, the block passes a one-cycle token to the next double column.

The block also runs the parallel configuration load. During that load it forwards a serial configuration bit into its column for a fixed number of cycles. It drives the column's clock enable so that the column is clocked only during its own readout or its own configuration load.

Top module: `eoc_column_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `sdo_valid`, `token_out`, `col_clk_en`, `cfg_shift` and `col_cfg_bit` are low.
- R2: When `token_in` is high at a clock edge while the block is idle, `sdo_valid` is high in the following cycle. The first bit of the stream is the column flag, which is 1 exactly when any bit of `pix_hit` is set.
- R3: A column with no hit produces a one-bit stream (a single 0), followed by the token.
- R4: Pixel index p belongs to super-pixel p / (2*SP_ROWS). When the column flag is 1, each super-pixel 0, 1, ... emits a flag, which is the OR of its pixels' hit bits. A clear flag skips all of that super-pixel's pixels.
- R5: Inside a super-pixel whose flag is set, each pixel emits its `pix_hit` bit in ascending index order. A clear bit sends no data for that pixel.
- R6: A pixel whose hit bit is set emits its DW-bit word `pix_data[p*DW +: DW]` right after its flag, most significant bit first.
- R7: `token_out` is a one-cycle pulse in the cycle right after the last stream bit. After it, the block is idle.
- R8: A `token_in` that arrives while a readout or a configuration load is in progress is ignored: no second stream follows.
- R9: `col_clk_en` is high exactly in the cycles in which `sdo_valid`, `cfg_shift` or `token_out` is high.
- R10: A `cfg_start` at an idle clock edge, with `token_in` low, holds `cfg_shift` high for exactly 2*ROWS*CFG_W consecutive cycles, starting in the next cycle. During those cycles `col_cfg_bit` equals `cfg_bit`; outside them it is 0. If `token_in` and `cfg_start` arrive together, the readout wins and the configuration request is dropped.
- R11: `sdo_valid` stays high in every cycle from the first stream bit to the last one, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| token_in | input | 1 | Start-of-readout token from the previous double column |
| pix_hit | input | 2*ROWS | Hit bit of each pixel, index ordered by super-pixel |
| pix_data | input | 2*ROWS*DW | Data word of each pixel, pixel p at bits p*DW +: DW |
| cfg_start | input | 1 | Begin the parallel configuration load |
| cfg_bit | input | 1 | Serial configuration bit, broadcast to all columns |
| sdo | output | 1 | Serial readout bit |
| sdo_valid | output | 1 | `sdo` carries a stream bit this cycle |
| token_out | output | 1 | Start token to the next double column |
| col_clk_en | output | 1 | Clock enable for this double column |
| cfg_shift | output | 1 | Column configuration registers shift this cycle |
| col_cfg_bit | output | 1 | Configuration bit forwarded into the column |

## Verification
The bench builds the block with ROWS=16, SP_ROWS=8, DW=4 and CFG_W=2. That gives 32 pixels in two super-pixels, 4-bit words and a 64-cycle configuration load. With only two super-pixels, a run can place hits in one super-pixel only, in the other only, or in both. It can also place them at the very first and very last pixel, so that both the first and the last iteration of the pixel, super-pixel and bit counters are exercised. The short streams and the short load keep each token hand-off and each collision of a token with a busy cycle only a few dozen cycles apart.

// File: rtl/eoc_pkg.sv
package eoc_pkg;

    // Readout walk states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLF,   // column flag bit
        ST_SPF,    // super-pixel flag bit
        ST_PIXF,   // pixel flag bit
        ST_DATA,   // pixel data bits
        ST_PASS    // token hand-off cycle
    } rd_state_e;

    // Serial side of the sequencer
    typedef struct packed {
        logic bit_out;
        logic valid;
        logic token;
        logic clk_en;
    } rd_out_t;

    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/eoc_hit_tree.sv
module eoc_hit_tree #(
    parameter int NPIX    = 128,
    parameter int SP_SIZE = 16,
    localparam int NSP    = NPIX / SP_SIZE
) (
    input  logic [NPIX-1:0] pix_hit,
    output logic [NSP-1:0]  sp_hit,
    output logic            col_hit
);

    // One OR reduction per super-pixel
    for (genvar g = 0; g < NSP; g++) begin : g_sp
        assign sp_hit[g] = |pix_hit[g*SP_SIZE +: SP_SIZE];
    end

    assign col_hit = |sp_hit;

endmodule

// File: rtl/eoc_cfg_loader.sv
module eoc_cfg_loader #(
    parameter int TOTAL = 512,
    localparam int CW   = $clog2(TOTAL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cfg_bit,
    output logic busy,
    output logic col_cfg_bit
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (cnt == CW'(TOTAL - 1)) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign col_cfg_bit = busy & cfg_bit;

endmodule

// File: rtl/eoc_readout_fsm.sv
module eoc_readout_fsm
    import eoc_pkg::*;
#(
    parameter int NPIX    = 128,
    parameter int SP_SIZE = 16,
    parameter int DW      = 8,
    localparam int NSP    = NPIX / SP_SIZE,
    localparam int SPW    = idx_w(NSP),
    localparam int INW    = idx_w(SP_SIZE),
    localparam int BW     = idx_w(DW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NPIX-1:0]    pix_hit,
    input  logic [NPIX*DW-1:0] pix_data,
    input  logic [NSP-1:0]     sp_hit,
    input  logic               col_hit,
    output logic               idle,
    output rd_out_t            rd_out
);

    rd_state_e          state;
    rd_state_e          adv_state;
    logic [SPW-1:0]     sp_idx;
    logic [INW-1:0]     pix_idx;
    logic [BW-1:0]      bit_idx;
    logic [SPW+INW-1:0] flat;
    logic [DW-1:0]      cur_word;
    logic               sp_last;
    logic               pix_last;
    logic               bit_last;

    assign flat     = {sp_idx, pix_idx};
    assign cur_word = pix_data[int'(flat)*DW +: DW];
    assign sp_last  = (sp_idx == SPW'(NSP - 1));
    assign pix_last = (pix_idx == INW'(SP_SIZE - 1));
    assign bit_last = (bit_idx == BW'(DW - 1));

    // State after the current pixel is finished
    always_comb begin
        if (!pix_last)
            adv_state = ST_PIXF;
        else if (!sp_last)
            adv_state = ST_SPF;
        else
            adv_state = ST_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sp_idx  <= '0;
            pix_idx <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_COLF;
                        sp_idx  <= '0;
                        pix_idx <= '0;
                        bit_idx <= '0;
                    end
                end
                ST_COLF: state <= col_hit ? ST_SPF : ST_PASS;
                ST_SPF: begin
                    pix_idx <= '0;
                    if (sp_hit[sp_idx])
                        state <= ST_PIXF;
                    else if (sp_last)
                        state <= ST_PASS;
                    else
                        sp_idx <= sp_idx + 1'b1;
                end
                ST_PIXF: begin
                    bit_idx <= '0;
                    if (pix_hit[flat]) begin
                        state <= ST_DATA;
                    end else begin
                        state <= adv_state;
                        if (!pix_last) pix_idx <= pix_idx + 1'b1;
                        else if (!sp_last) sp_idx <= sp_idx + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_last) begin
                        state <= adv_state;
                        if (!pix_last) pix_idx <= pix_idx + 1'b1;
                        else if (!sp_last) sp_idx <= sp_idx + 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_PASS: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle = (state == ST_IDLE);

    always_comb begin
        rd_out.valid  = (state == ST_COLF) || (state == ST_SPF) ||
                        (state == ST_PIXF) || (state == ST_DATA);
        rd_out.token  = (state == ST_PASS);
        rd_out.clk_en = (state != ST_IDLE);
        case (state)
            ST_COLF: rd_out.bit_out = col_hit;
            ST_SPF:  rd_out.bit_out = sp_hit[sp_idx];
            ST_PIXF: rd_out.bit_out = pix_hit[flat];
            ST_DATA: rd_out.bit_out = cur_word[BW'(DW - 1) - bit_idx];
            default: rd_out.bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/eoc_column_seq.sv
module eoc_column_seq
    import eoc_pkg::*;
#(
    parameter int ROWS    = 64,
    parameter int SP_ROWS = 8,
    parameter int DW      = 8,
    parameter int CFG_W   = 4,
    localparam int NPIX   = 2 * ROWS,
    localparam int SP_SIZE = 2 * SP_ROWS,
    localparam int NSP    = NPIX / SP_SIZE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               token_in,
    input  logic [NPIX-1:0]    pix_hit,
    input  logic [NPIX*DW-1:0] pix_data,
    input  logic               cfg_start,
    input  logic               cfg_bit,
    output logic               sdo,
    output logic               sdo_valid,
    output logic               token_out,
    output logic               col_clk_en,
    output logic               cfg_shift,
    output logic               col_cfg_bit
);

    logic [NSP-1:0] sp_hit;
    logic           col_hit;
    logic           rd_idle;
    logic           cfg_busy;
    logic           rd_go;
    logic           cfg_go;
    rd_out_t        rd_out;

    // Readout beats configuration when both requests land together
    assign rd_go  = token_in & rd_idle & ~cfg_busy;
    assign cfg_go = cfg_start & ~token_in & rd_idle & ~cfg_busy;

    eoc_hit_tree #(
        .NPIX    (NPIX),
        .SP_SIZE (SP_SIZE)
    ) u_tree (
        .pix_hit (pix_hit),
        .sp_hit  (sp_hit),
        .col_hit (col_hit)
    );

    eoc_readout_fsm #(
        .NPIX    (NPIX),
        .SP_SIZE (SP_SIZE),
        .DW      (DW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_go),
        .pix_hit  (pix_hit),
        .pix_data (pix_data),
        .sp_hit   (sp_hit),
        .col_hit  (col_hit),
        .idle     (rd_idle),
        .rd_out   (rd_out)
    );

    eoc_cfg_loader #(
        .TOTAL (NPIX * CFG_W)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .start       (cfg_go),
        .cfg_bit     (cfg_bit),
        .busy        (cfg_busy),
        .col_cfg_bit (col_cfg_bit)
    );

    assign sdo        = rd_out.bit_out & rd_out.valid;
    assign sdo_valid  = rd_out.valid;
    assign token_out  = rd_out.token;
    assign cfg_shift  = cfg_busy;
    assign col_clk_en = rd_out.clk_en | cfg_busy;

endmodule

// File: rtl/eoc_column_seq_chk.sv
module eoc_column_seq_chk (
    input logic clk,
    input logic rst,
    input logic token_in,
    input logic cfg_start,
    input logic sdo_valid,
    input logic token_out,
    input logic col_clk_en,
    input logic cfg_shift
);

    // R7
    token_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        token_out |=> !token_out);

    // R7
    token_after_bits_chk: assert property (@(posedge clk) disable iff (rst)
        token_out |-> $past(sdo_valid));

    // R11
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_valid |=> (sdo_valid || token_out));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (token_in && !col_clk_en) |=> sdo_valid);

    // R10
    cfg_begin_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_start && !token_in && !col_clk_en) |=> cfg_shift);

    // R10
    cfg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_shift && (sdo_valid || token_out)));

    // R9
    gate_on_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_valid || cfg_shift || token_out) |-> col_clk_en);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_shift && token_in) |=> !sdo_valid);

endmodule

bind eoc_column_seq eoc_column_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .token_in   (token_in),
    .cfg_start  (cfg_start),
    .sdo_valid  (sdo_valid),
    .token_out  (token_out),
    .col_clk_en (col_clk_en),
    .cfg_shift  (cfg_shift)
);

// File: tb/eoc_column_seq_tb.sv
module eoc_column_seq_tb;

    localparam int ROWS    = 16;
    localparam int SP_ROWS = 8;
    localparam int DW      = 4;
    localparam int CFG_W   = 2;
    localparam int NPIX    = 2 * ROWS;
    localparam int SP_SIZE = 2 * SP_ROWS;
    localparam int NSP     = NPIX / SP_SIZE;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               token_in = 1'b0;
    logic [NPIX-1:0]    pix_hit = '0;
    logic [NPIX*DW-1:0] pix_data = '0;
    logic               cfg_start = 1'b0;
    logic               cfg_bit = 1'b0;
    logic               sdo, sdo_valid, token_out, col_clk_en, cfg_shift, col_cfg_bit;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    int tok_cnt = 0;
    bit prev_valid = 1'b0;
    bit prev_tok = 1'b0;
    bit exp_q[$];

    always #2.5 clk = ~clk;

    eoc_column_seq #(
        .ROWS(ROWS), .SP_ROWS(SP_ROWS), .DW(DW), .CFG_W(CFG_W)
    ) u_dut (
        .clk(clk), .rst(rst), .token_in(token_in), .pix_hit(pix_hit),
        .pix_data(pix_data), .cfg_start(cfg_start), .cfg_bit(cfg_bit),
        .sdo(sdo), .sdo_valid(sdo_valid), .token_out(token_out),
        .col_clk_en(col_clk_en), .cfg_shift(cfg_shift), .col_cfg_bit(col_cfg_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver side: expected stream from R2, R4, R5, R6
    task automatic push_expected();
        bit any;
        any = |pix_hit;
        exp_q.push_back(any);
        if (any) begin
            for (int s = 0; s < NSP; s++) begin
                bit f;
                f = |pix_hit[s*SP_SIZE +: SP_SIZE];
                exp_q.push_back(f);
                if (f) begin
                    for (int i = 0; i < SP_SIZE; i++) begin
                        int p;
                        p = s * SP_SIZE + i;
                        exp_q.push_back(pix_hit[p]);
                        if (pix_hit[p])
                            for (int b = DW - 1; b >= 0; b--)
                                exp_q.push_back(pix_data[p*DW + b]);
                    end
                end
            end
        end
    endtask

    // Monitor: scoreboard compare and per-cycle port rules
    always @(negedge clk) begin
        if (!rst) begin
            if (sdo_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected stream bit", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    // R4 R5 R6 stream content
                    check(sdo == e, "R4/R5/R6 stream bit", int'(sdo), int'(e));
                end
                rx_cnt++;
            end
            if (token_out) begin
                tok_cnt++;
                // R7 token right after last bit
                check(exp_q.size() == 0 && prev_valid, "R7 token timing",
                      exp_q.size(), 0);
            end
            if (prev_tok) check(!token_out, "R7 token one cycle", int'(token_out), 0);
            // R9
            check(col_clk_en == (sdo_valid | cfg_shift | token_out), "R9 clock enable",
                  int'(col_clk_en), int'(sdo_valid | cfg_shift | token_out));
            // R10
            check(col_cfg_bit == (cfg_shift & cfg_bit), "R10 config bit",
                  int'(col_cfg_bit), int'(cfg_shift & cfg_bit));
            prev_valid = sdo_valid;
            prev_tok   = token_out;
        end
    end

    task automatic run_column(input bit inject_token);
        int len, n, t0;
        push_expected();
        len = exp_q.size();
        rx_cnt = 0;
        t0 = tok_cnt;
        @(negedge clk);
        token_in = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
        // R2 first bit in the cycle after the token edge
        check(sdo_valid == 1'b1, "R2 stream start", int'(sdo_valid), 1);
        n = 0;
        while (tok_cnt == t0 && n < 2000) begin
            if (inject_token && n == 3) token_in = 1'b1;
            else token_in = 1'b0;
            @(negedge clk);
            n++;
        end
        token_in = 1'b0;
        repeat (6) @(negedge clk);
        // R11 every bit delivered, none extra (R8)
        check(rx_cnt == len, "R11 stream length", rx_cnt, len);
        check(tok_cnt == t0 + 1, "R7 single token", tok_cnt - t0, 1);
    endtask

    task automatic fill_data(input int seed);
        for (int p = 0; p < NPIX; p++) pix_data[p*DW +: DW] = DW'(p * 5 + seed);
    endtask

    initial begin
        int n;
        fill_data(3);
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!sdo_valid && !token_out && !col_clk_en && !cfg_shift && !col_cfg_bit,
              "R1 reset outputs", int'(col_clk_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!sdo_valid && !token_out && !col_clk_en && !cfg_shift,
              "R1 after reset", int'(sdo_valid), 0);

        // R3 empty column
        pix_hit = '0;
        run_column(1'b0);
        check(rx_cnt == 1, "R3 empty column length", rx_cnt, 1);

        // R6 every pixel hit
        pix_hit = '1;
        run_column(1'b0);

        // R4 only super-pixel 1 hit
        pix_hit = '0;
        pix_hit[20] = 1'b1;
        fill_data(7);
        run_column(1'b0);

        // R4 R5 first and last pixel only
        pix_hit = '0;
        pix_hit[0] = 1'b1;
        pix_hit[NPIX-1] = 1'b1;
        run_column(1'b0);

        // R5 sparse pattern in super-pixel 0, token repeated while busy (R8)
        pix_hit = 32'h0000_9245;
        fill_data(11);
        run_column(1'b1);

        // R5 mixed pattern in both super-pixels
        pix_hit = 32'h8001_6c30;
        run_column(1'b0);

        // R10 configuration load, with a token arriving mid-load (R8)
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        n = 0;
        while (cfg_shift && n < 1000) begin
            n++;
            cfg_bit = n[1];
            token_in = (n == 3);
            @(negedge clk);
        end
        token_in = 1'b0;
        cfg_bit = 1'b0;
        check(n == NPIX * CFG_W, "R10 config length", n, NPIX * CFG_W);
        repeat (5) @(negedge clk);
        check(!sdo_valid && !cfg_shift, "R8 token ignored during config",
              int'(sdo_valid), 0);

        // R10 simultaneous request: readout wins, config dropped
        pix_hit = '0;
        push_expected();
        rx_cnt = 0;
        @(negedge clk);
        token_in = 1'b1;
        cfg_start = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
        cfg_start = 1'b0;
        check(sdo_valid && !cfg_shift, "R10 readout priority", int'(cfg_shift), 0);
        n = 0;
        repeat (8) begin
            @(negedge clk);
            if (cfg_shift) n++;
        end
        check(n == 0, "R10 dropped config request", n, 0);
        check(rx_cnt == 1, "R3 stream after collision", rx_cnt, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule